// File: doc/BRIEF.md
# Hi/Lo Multiply-Divide Unit

This block sits beside an integer datapath and performs 32-bit multiplication and division, signed or unsigned, over many cycles. It owns two dedicated result registers, Hi and Lo. A multiply leaves the full 64-bit product split across them. A divide leaves the remainder in Hi and the quotient in Lo.

An operation starts when the function-code input selects one of the four arithmetic codes and the start strobe is high while the unit is idle. Multiplication uses a radix-2 shift-and-add loop. Division uses a restoring shift-and-subtract loop. Both loops work on operand magnitudes, and a final cycle corrects the signs.

The same function-code input also selects which result register drives the read port. The register file can therefore copy Hi or Lo at any time. During a running operation those reads return the last completed result.

Top module: `hiLoMulDiv`

## Requirements
- R1: After reset, Hi and Lo hold zero, and busy and done are low.
- R2: Function code 24 with start computes the signed 64-bit product of srcA and srcB, with the upper 32 bits in Hi and the lower 32 bits in Lo.
- R3: Function code 25 with start computes the unsigned 64-bit product, split into Hi and Lo the same way as R2.
- R4: Function code 26 with start performs signed division. Lo receives the quotient, truncated toward zero. Hi receives the remainder, which carries the sign of the dividend. The quotient of 0x80000000 divided by -1 wraps to 0x80000000.
- R5: Function code 27 with start performs unsigned division, with the remainder in Hi and the quotient in Lo.
- R6: A division whose divisor is zero completes with normal timing and leaves Lo = 0xFFFFFFFF and Hi = the dividend operand unchanged.
- R7: An accepted start raises busy at the next clock edge. Busy stays high for 33 cycles. At the edge where busy falls, done is high for exactly one cycle and Hi/Lo hold the new result.
- R8: A start request while busy is ignored. The running operation finishes with its original operands, and no second result is produced.
- R9: readData shows Hi when funcCode is 16, shows Lo when funcCode is 18, and shows zero for any other code, without waiting for a clock edge. While busy, it returns the previous result.
- R10: A start request with a function code outside 24 to 27 is ignored: busy stays low and Hi/Lo keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start strobe for an arithmetic code |
| funcCode | input | 6 | Operation or read selector |
| srcA | input | 32 | Multiplicand or dividend |
| srcB | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| readData | output | 32 | Hi or Lo as selected by funcCode |

## Verification
A read of Hi or Lo can share a cycle with a running operation. A fresh start request can also arrive while the iteration loop is still running. The bench reads both registers in the middle of an operation and expects the previous result, since the new values appear only in the done cycle. It also fires a second start with different operands part-way through a multiply. That start must leave busy high, and the scoreboard must receive exactly the first result and no extra done pulse.

// File: rtl/hlmd_pkg.sv
package hlmd_pkg;
  localparam logic [5:0] FN_MFHI  = 6'd16;
  localparam logic [5:0] FN_MFLO  = 6'd18;
  localparam logic [5:0] FN_MULT  = 6'd24;
  localparam logic [5:0] FN_MULTU = 6'd25;
  localparam logic [5:0] FN_DIV   = 6'd26;
  localparam logic [5:0] FN_DIVU  = 6'd27;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } hlmdStrobe_t;

  function automatic logic isArith(input logic [5:0] f);
    return (f == FN_MULT) || (f == FN_MULTU) || (f == FN_DIV) || (f == FN_DIVU);
  endfunction
endpackage

// File: rtl/hlmd_ctrl.sv
module hlmd_ctrl
  import hlmd_pkg::*;
#(
  parameter int ITERS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic [5:0]  funcCode,
  output hlmdStrobe_t strobes,
  output logic        busy,
  output logic        done
);
  localparam int CNT_W = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ITERS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIX} ctrlState_t;

  ctrlState_t state;
  logic [CNT_W-1:0] iterCnt;
  logic accept;

  assign accept = (state == ST_IDLE) && startValid && isArith(funcCode);
  assign busy   = (state != ST_IDLE);

  always_comb begin
    strobes.load   = accept;
    strobes.step   = (state == ST_RUN);
    strobes.finish = (state == ST_FIX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_RUN;
          iterCnt <= '0;
        end
        ST_RUN: begin
          iterCnt <= iterCnt + 1'b1;
          if (iterCnt == LAST) state <= ST_FIX;
        end
        ST_FIX: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: completion pulse only once busy has dropped
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);
  // R7: done lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R7: busy only falls together with done
  a_r7_fall_done: assert property (@(posedge clk) disable iff (!rstN) $fell(busy) |-> done);
  // R8: a start during the loop does not disturb it
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) && (iterCnt != LAST) && startValid |=> busy && !done);
  // R10: non-arithmetic codes never launch an operation
  a_r10_bad_code: assert property (@(posedge clk) disable iff (!rstN)
    !busy && startValid && !isArith(funcCode) |=> !busy);
endmodule

// File: rtl/hlmd_datapath.sv
module hlmd_datapath
  import hlmd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  hlmdStrobe_t       strobes,
  input  logic [5:0]        funcCode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] readData
);
  localparam int ACC_W = 2 * DATA_W + 1;

  logic [DATA_W-1:0] hiReg, loReg;
  logic [DATA_W-1:0] aOrig, bOrig, magB;
  logic [ACC_W-1:0]  acc, accNext;
  logic              opDiv, opSigned;
  logic              negA, negB;

  logic [DATA_W:0]   mulSum, mulAdd;
  logic [ACC_W-1:0]  divShift;
  logic [DATA_W:0]   divTop;
  logic [2*DATA_W-1:0] prodFix;
  logic [DATA_W-1:0] quoFix, remFix;
  logic              loadSigned;
  logic [DATA_W-1:0] loadMagA, loadMagB;

  assign negA = opSigned & aOrig[DATA_W-1];
  assign negB = opSigned & bOrig[DATA_W-1];

  assign loadSigned = ~funcCode[0];
  assign loadMagA = (loadSigned && srcA[DATA_W-1]) ? (~srcA + 1'b1) : srcA;
  assign loadMagB = (loadSigned && srcB[DATA_W-1]) ? (~srcB + 1'b1) : srcB;

  // one iteration of each loop
  always_comb begin
    mulAdd   = acc[0] ? {1'b0, magB} : '0;
    mulSum   = {1'b0, acc[2*DATA_W-1:DATA_W]} + mulAdd;
    divShift = {acc[2*DATA_W-1:0], 1'b0};
    divTop   = divShift[ACC_W-1:DATA_W];
    if (!opDiv) begin
      accNext = {1'b0, mulSum, acc[DATA_W-1:1]};
    end else if (divTop >= {1'b0, magB}) begin
      accNext = {divTop - {1'b0, magB}, divShift[DATA_W-1:1], 1'b1};
    end else begin
      accNext = divShift;
    end
  end

  // sign fix-up of the magnitude results
  always_comb begin
    prodFix = (negA ^ negB) ? (~acc[2*DATA_W-1:0] + 1'b1) : acc[2*DATA_W-1:0];
    quoFix  = (negA ^ negB) ? (~acc[DATA_W-1:0] + 1'b1) : acc[DATA_W-1:0];
    remFix  = negA ? (~acc[2*DATA_W-1:DATA_W] + 1'b1) : acc[2*DATA_W-1:DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg    <= '0;
      loReg    <= '0;
      aOrig    <= '0;
      bOrig    <= '0;
      magB     <= '0;
      acc      <= '0;
      opDiv    <= 1'b0;
      opSigned <= 1'b0;
    end else begin
      if (strobes.load) begin
        opDiv    <= funcCode[1];
        opSigned <= loadSigned;
        aOrig    <= srcA;
        bOrig    <= srcB;
        magB     <= loadMagB;
        acc      <= {{(DATA_W+1){1'b0}}, loadMagA};
      end else if (strobes.step) begin
        acc <= accNext;
      end
      if (strobes.finish) begin
        if (!opDiv) begin
          hiReg <= prodFix[2*DATA_W-1:DATA_W];
          loReg <= prodFix[DATA_W-1:0];
        end else if (bOrig == '0) begin
          hiReg <= aOrig;
          loReg <= '1;
        end else begin
          hiReg <= remFix;
          loReg <= quoFix;
        end
      end
    end
  end

  always_comb begin
    case (funcCode)
      FN_MFHI: readData = hiReg;
      FN_MFLO: readData = loReg;
      default: readData = '0;
    endcase
  end

  // R9: result registers change only in the completion cycle
  a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.finish |=> $stable(hiReg) && $stable(loReg));
  // R6: zero divisor gives all-ones quotient and keeps the dividend
  a_r6_div_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish && opDiv && (bOrig == '0) |=> (loReg == '1) && (hiReg == $past(aOrig)));
  // R4: signed remainder never disagrees with the dividend sign
  a_r4_rem_sign: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish && opDiv && opSigned && (bOrig != '0) && !aOrig[DATA_W-1]
    |=> !hiReg[DATA_W-1]);
endmodule

// File: rtl/hiLoMulDiv.sv
module hiLoMulDiv
  import hlmd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [5:0]        funcCode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] readData
);
  hlmdStrobe_t strobes;

  hlmd_ctrl #(.ITERS(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .funcCode(funcCode),
    .strobes(strobes), .busy(busy), .done(done)
  );

  hlmd_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .funcCode(funcCode),
    .srcA(srcA), .srcB(srcB), .readData(readData)
  );
endmodule

// File: tb/hiLoMulDiv_tb.sv
module hiLoMulDiv_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic        drvActive = 1'b0;
  logic [5:0]  drvFunc = 6'd0;
  logic [5:0]  monFunc = 6'd0;
  logic [5:0]  funcCode;
  logic [31:0] srcA = '0, srcB = '0;
  logic        busy, done;
  logic [31:0] readData;

  int checks = 0;
  int fails = 0;
  logic [63:0] expQ[$];
  string       tagQ[$];
  logic [63:0] lastRes = '0;

  assign funcCode = drvActive ? drvFunc : monFunc;

  always #(CLK_PERIOD/2) clk = ~clk;

  hiLoMulDiv u_dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .funcCode(funcCode),
    .srcA(srcA), .srcB(srcB), .busy(busy), .done(done), .readData(readData)
  );

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic logic [63:0] model(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, sq, sr;
    logic [63:0] ua, ub;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = {32'b0, a};
    ub = {32'b0, b};
    case (f)
      6'd24: return 64'(sa * sb);
      6'd25: return ua * ub;
      6'd26: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        sq = sa / sb;
        sr = sa % sb;
        return {sr[31:0], sq[31:0]};
      end
      6'd27: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        return {a % b, a / b};
      end
      default: return 64'd0;
    endcase
  endfunction

  // monitor: pops the scoreboard at each done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (expQ.size() == 0) begin
          checks++;
          fails++;
          $display("FAIL R8 unexpected done actual=1 expected=0");
        end else begin
          logic [63:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          monFunc = 6'd16;
          #1 checkEq({t, " Hi"}, readData, e[63:32]);
          monFunc = 6'd18;
          #1 checkEq({t, " Lo"}, readData, e[31:0]);
          monFunc = 6'd0;
          lastRes = e;
        end
      end
    end
  end

  task automatic issueStart(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    drvActive = 1'b1;
    drvFunc = f;
    srcA = a;
    srcB = b;
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    drvActive = 1'b0;
  endtask

  task automatic runOp(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b, input string tag);
    expQ.push_back(model(f, a, b));
    tagQ.push_back(tag);
    issueStart(f, a, b);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic readReg(input logic [5:0] f, output logic [31:0] v);
    drvActive = 1'b1;
    drvFunc = f;
    #1 v = readData;
    drvActive = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [31:0] v;
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkEq("R1 busy", {31'b0, busy}, 32'd0);
    checkEq("R1 done", {31'b0, done}, 32'd0);
    readReg(6'd16, v); checkEq("R1 Hi", v, 32'd0);
    readReg(6'd18, v); checkEq("R1 Lo", v, 32'd0);

    runOp(6'd24, 32'd7, 32'hFFFF_FFFD, "R2 7*-3");
    runOp(6'd24, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 -1*-1");
    runOp(6'd24, 32'h8000_0000, 32'h8000_0000, "R2 min*min");
    runOp(6'd24, 32'h1234_5678, 32'h0000_0000, "R2 x*0");
    runOp(6'd25, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 max*max");
    runOp(6'd25, 32'd123456, 32'd789, "R3 small");
    runOp(6'd26, 32'd100, 32'hFFFF_FFF9, "R4 100/-7");
    runOp(6'd26, 32'hFFFF_FF9C, 32'd7, "R4 -100/7");
    runOp(6'd26, 32'h8000_0000, 32'hFFFF_FFFF, "R4 min/-1");
    runOp(6'd27, 32'hFFFF_FFFF, 32'd16, "R5 max/16");
    runOp(6'd27, 32'd5, 32'd9, "R5 5/9");
    runOp(6'd26, 32'd37, 32'd0, "R6 signed 37/0");
    runOp(6'd26, 32'hFFFF_FFFB, 32'd0, "R6 signed -5/0");
    runOp(6'd27, 32'hDEAD_BEEF, 32'd0, "R6 unsigned /0");

    // R7 timing
    expQ.push_back(model(6'd27, 32'd1000, 32'd3));
    tagQ.push_back("R7 result");
    issueStart(6'd27, 32'd1000, 32'd3);
    cnt = 0;
    while (busy && cnt < 100) begin cnt++; @(negedge clk); end
    checkEq("R7 busy cycles", cnt, 32'd33);
    checkEq("R7 done at fall", {31'b0, done}, 32'd1);
    @(negedge clk);
    checkEq("R7 done one cycle", {31'b0, done}, 32'd0);

    // R8 and R9: start and reads while busy
    expQ.push_back(model(6'd24, 32'd300, 32'd400));
    tagQ.push_back("R8 first op kept");
    issueStart(6'd24, 32'd300, 32'd400);
    repeat (3) @(negedge clk);
    readReg(6'd16, v); checkEq("R9 Hi while busy", v, lastRes[63:32]);
    readReg(6'd18, v); checkEq("R9 Lo while busy", v, lastRes[31:0]);
    issueStart(6'd26, 32'd999, 32'd7);
    checkEq("R8 still busy", {31'b0, busy}, 32'd1);
    while (busy) @(negedge clk);
    repeat (45) @(negedge clk);
    checkEq("R8 no second run", {31'b0, busy}, 32'd0);
    readReg(6'd24, v); checkEq("R9 other code reads zero", v, 32'd0);

    // R10 non-arithmetic start codes
    issueStart(6'd16, 32'd5, 32'd6);
    checkEq("R10 code16 busy", {31'b0, busy}, 32'd0);
    issueStart(6'd32, 32'd5, 32'd6);
    checkEq("R10 code32 busy", {31'b0, busy}, 32'd0);
    repeat (40) @(negedge clk);
    readReg(6'd16, v); checkEq("R10 Hi kept", v, lastRes[63:32]);
    readReg(6'd18, v); checkEq("R10 Lo kept", v, lastRes[31:0]);
    checkEq("R8 scoreboard drained", expQ.size(), 32'd0);
    report();
  end
endmodule